// File: doc/BRIEF.md
# Single-Bit Sector ECC Corrector

This block checks one flash sector against a 24-bit code that corrects a single bit. It receives the code stored with the sector and the code freshly computed over the data read back. Each code arrives as three bytes. The block works out the difference between the two codes and sorts it into one of four outcomes:

- the data is clean;
- one data bit has flipped and can be repaired;
- a single bit of the stored code itself is damaged;
- the damage is beyond repair.

When a data bit can be repaired, the block fixes it in place. It reads the faulty byte from the sector buffer, inverts the faulty bit and writes the byte back. The buffer is a byte-wide, single-port, synchronous memory with one cycle of read latency.

A controller presents both codes together with a one-cycle start strobe while the block is idle. It then waits for the one-cycle done strobe. At that point the block presents the status code and, for a repaired bit, the byte position and the bit position it changed. Computing the parity over the data stream is left to a separate unit.

Top module: `sec_ecc_fixer`

## Requirements
- R1: Each code is formed little-endian from its bytes: byte 0 is bits [7:0], byte 1 is bits [15:8] and byte 2 is bits [23:16]. The difference is the bitwise XOR of the stored and computed values.
- R2: A zero difference gives status 0. The buffer is not accessed.
- R3: When the low 12 bits of the difference XOR its upper 12 bits equal 0xFFF, the error is in the data. The bit position is difference bits [14:12], the byte position is difference bits [23:15], and the status is 1.
- R4: A data repair reads the addressed byte in the first cycle after the start is accepted. In the next cycle it writes the same address with the byte read XOR (1 << bit position). No other buffer access takes place.
- R5: When the halves are complementary but the byte position is not below SECTOR_BYTES, the status is 3 and the buffer is not accessed.
- R6: A difference with exactly one bit set gives status 2. No data is changed.
- R7: Any other nonzero difference gives status 3 and no buffer access.
- R8: done_o is a one-cycle pulse. It comes 1 cycle after the accepted start when there is no repair, and 3 cycles after it when there is a repair. status_o is valid while done_o is high.
- R9: A start presented while busy_o is high is ignored. It does not alter the running check's result, its buffer accesses or its number of done pulses.
- R10: The byte and bit outputs are zero unless the status is 1.
- R11: During and right after reset, done_o, busy_o and buf_en_o are low and status_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| stored_code_i | input | 3x8 | Code read back from the spare area, byte 0 least significant |
| calc_code_i | input | 3x8 | Code computed over the data read back |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | 0 clean, 1 data bit repaired, 2 code bit damaged, 3 uncorrectable |
| byte_idx_o | output | 9 | Byte position of the repaired bit |
| bit_idx_o | output | 3 | Bit position of the repaired bit |
| buf_en_o | output | 1 | Sector buffer access enable |
| buf_we_o | output | 1 | Sector buffer write enable (read when low) |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_wdata_o | output | 8 | Sector buffer write data |
| buf_rdata_i | input | 8 | Sector buffer read data, one cycle after a read |

## Verification
The assertions rely on a few properties of the buffer:
- it returns data exactly one cycle after a read;
- it does not change the addressed byte between that read and the following write.

Given these, every write must differ from the byte just read in exactly one bit.

The bench models the buffer behaviourally with that latency. It drives start only on falling edges, for one cycle. Its only back-to-back request is the deliberate start issued while the block is busy.

The bench builds its code pairs by XORing a chosen difference into the stored bytes. This keeps every difference it applies known in advance. The design is instantiated with a 400-byte sector so that byte positions past the end of the sector can be reached.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN = 2'd0,
      ST_FIXED = 2'd1,
      ST_CODE  = 2'd2,
      ST_FATAL = 2'd3
   } ecc_status_e;

   typedef enum logic [1:0] {
      T_IDLE = 2'd0,
      T_FIX  = 2'd1,
      T_DONE = 2'd2
   } top_state_e;

   typedef enum logic [1:0] {
      M_IDLE = 2'd0,
      M_RD   = 2'd1,
      M_WR   = 2'd2
   } rmw_state_e;

endpackage

// File: rtl/sec_diff_classify.sv
module sec_diff_classify
   import ecc1_pkg::*;
#(
   parameter int CODE_BYTES   = 3,
   parameter int SECTOR_BYTES = 512,
   parameter int BIT_W        = 3,
   localparam int CODE_W      = 8 * CODE_BYTES,
   localparam int HALF_W      = CODE_W / 2,
   localparam int IDX_W       = HALF_W - BIT_W
) (
   input  logic [CODE_BYTES-1:0][7:0] stored_i,
   input  logic [CODE_BYTES-1:0][7:0] calc_i,
   output ecc_status_e                kind_o,
   output logic [IDX_W-1:0]           byte_o,
   output logic [BIT_W-1:0]           bit_o
);

   logic [CODE_W-1:0] stored_w;
   logic [CODE_W-1:0] calc_w;
   logic [CODE_W-1:0] diff_w;
   logic [HALF_W-1:0] lo_half;
   logic [HALF_W-1:0] hi_half;
   logic              halves_compl;
   logic              single_bit;
   logic              in_range;
   logic [IDX_W-1:0]  byte_raw;
   logic [BIT_W-1:0]  bit_raw;

   // little-endian assembly, byte g lands at bits [8g+7:8g]
   generate
      for (genvar g = 0; g < CODE_BYTES; g++) begin : g_pack
         assign stored_w[8*g +: 8] = stored_i[g];
         assign calc_w[8*g +: 8]   = calc_i[g];
      end
   endgenerate

   assign diff_w       = stored_w ^ calc_w;
   assign lo_half      = diff_w[HALF_W-1:0];
   assign hi_half      = diff_w[CODE_W-1:HALF_W];
   assign halves_compl = ((lo_half ^ hi_half) == {HALF_W{1'b1}});
   assign bit_raw      = hi_half[BIT_W-1:0];
   assign byte_raw     = hi_half[HALF_W-1:BIT_W];
   assign single_bit   = (diff_w != '0) && ((diff_w & (diff_w - 1'b1)) == '0);

   // a sector that fills the whole index range needs no bounds compare
   generate
      if (SECTOR_BYTES == (1 << IDX_W)) begin : g_full_range
         assign in_range = 1'b1;
      end else begin : g_bounded
         assign in_range = (byte_raw < IDX_W'(SECTOR_BYTES));
      end
   endgenerate

   always_comb begin
      kind_o = ST_FATAL;
      byte_o = '0;
      bit_o  = '0;
      if (diff_w == '0) begin
         kind_o = ST_CLEAN;
      end else if (halves_compl) begin
         if (in_range) begin
            kind_o = ST_FIXED;
            byte_o = byte_raw;
            bit_o  = bit_raw;
         end else begin
            kind_o = ST_FATAL;
         end
      end else if (single_bit) begin
         kind_o = ST_CODE;
      end else begin
         kind_o = ST_FATAL;
      end
   end

endmodule

// File: rtl/sec_rmw_engine.sv
module sec_rmw_engine
   import ecc1_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int BIT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BIT_W-1:0]  bit_i,
   output logic              finish_o,
   output logic              buf_en_o,
   output logic              buf_we_o,
   output logic [ADDR_W-1:0] buf_addr_o,
   output logic [7:0]        buf_wdata_o,
   input  logic [7:0]        buf_rdata_i
);

   rmw_state_e        state_q;
   logic [7:0]        mask_q;
   logic [7:0]        mask_d;
   logic [ADDR_W-1:0] addr_q;

   generate
      for (genvar g = 0; g < 8; g++) begin : g_mask
         assign mask_d[g] = (bit_i == BIT_W'(g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= M_IDLE;
         mask_q  <= '0;
         addr_q  <= '0;
      end else begin
         case (state_q)
            M_IDLE: if (go_i) begin
               state_q <= M_RD;
               mask_q  <= mask_d;
               addr_q  <= addr_i;
            end
            M_RD:    state_q <= M_WR;
            M_WR:    state_q <= M_IDLE;
            default: state_q <= M_IDLE;
         endcase
      end
   end

   assign buf_en_o    = (state_q == M_RD) || (state_q == M_WR);
   assign buf_we_o    = (state_q == M_WR);
   assign buf_addr_o  = addr_q;
   assign buf_wdata_o = buf_rdata_i ^ mask_q;
   assign finish_o    = (state_q == M_WR);

   // R4
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> $past(buf_en_o && !buf_we_o));

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> $stable(buf_addr_o));

   // R4
   one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we_o |-> ($countones(buf_wdata_o ^ buf_rdata_i) == 1));

endmodule

// File: rtl/sec_ecc_fixer.sv
module sec_ecc_fixer
   import ecc1_pkg::*;
#(
   parameter int CODE_BYTES   = 3,
   parameter int SECTOR_BYTES = 512,
   localparam int BIT_W       = 3,
   localparam int IDX_W       = (8 * CODE_BYTES) / 2 - BIT_W,
   localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [CODE_BYTES-1:0][7:0] stored_code_i,
   input  logic [CODE_BYTES-1:0][7:0] calc_code_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic [1:0]                 status_o,
   output logic [IDX_W-1:0]           byte_idx_o,
   output logic [BIT_W-1:0]           bit_idx_o,
   output logic                       buf_en_o,
   output logic                       buf_we_o,
   output logic [ADDR_W-1:0]          buf_addr_o,
   output logic [7:0]                 buf_wdata_o,
   input  logic [7:0]                 buf_rdata_i
);

   generate
      if (CODE_BYTES < 2) begin : g_bad_code
         $error("CODE_BYTES must be at least 2");
      end
      if (SECTOR_BYTES < 2 || SECTOR_BYTES > (1 << IDX_W)) begin : g_bad_sector
         $error("SECTOR_BYTES must lie between 2 and the byte index range");
      end
   endgenerate

   top_state_e        state_q;
   ecc_status_e       kind_w;
   ecc_status_e       status_q;
   logic [IDX_W-1:0]  byte_w;
   logic [IDX_W-1:0]  byte_q;
   logic [BIT_W-1:0]  bit_w;
   logic [BIT_W-1:0]  bit_q;
   logic              accept;
   logic              rmw_go;
   logic              rmw_finish;

   sec_diff_classify #(
      .CODE_BYTES   (CODE_BYTES),
      .SECTOR_BYTES (SECTOR_BYTES),
      .BIT_W        (BIT_W)
   ) classify_i (
      .stored_i (stored_code_i),
      .calc_i   (calc_code_i),
      .kind_o   (kind_w),
      .byte_o   (byte_w),
      .bit_o    (bit_w)
   );

   assign accept = start_i && (state_q == T_IDLE);
   assign rmw_go = accept && (kind_w == ST_FIXED);

   sec_rmw_engine #(
      .ADDR_W (ADDR_W),
      .BIT_W  (BIT_W)
   ) rmw_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (rmw_go),
      .addr_i      (ADDR_W'(byte_w)),
      .bit_i       (bit_w),
      .finish_o    (rmw_finish),
      .buf_en_o    (buf_en_o),
      .buf_we_o    (buf_we_o),
      .buf_addr_o  (buf_addr_o),
      .buf_wdata_o (buf_wdata_o),
      .buf_rdata_i (buf_rdata_i)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= T_IDLE;
         status_q <= ST_CLEAN;
         byte_q   <= '0;
         bit_q    <= '0;
      end else begin
         case (state_q)
            T_IDLE: if (accept) begin
               status_q <= kind_w;
               byte_q   <= byte_w;
               bit_q    <= bit_w;
               state_q  <= (kind_w == ST_FIXED) ? T_FIX : T_DONE;
            end
            T_FIX:   if (rmw_finish) state_q <= T_DONE;
            T_DONE:  state_q <= T_IDLE;
            default: state_q <= T_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != T_IDLE);
   assign done_o     = (state_q == T_DONE);
   assign status_o   = status_q;
   assign byte_idx_o = byte_q;
   assign bit_idx_o  = bit_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   fixed_wrote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == ST_FIXED) |-> $past(buf_we_o));

   // R6
   nofix_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o != ST_FIXED) |-> !$past(buf_en_o));

   // R5
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == ST_FIXED) |-> (int'(byte_idx_o) < SECTOR_BYTES));

   // R10
   idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o != ST_FIXED) |-> (byte_idx_o == '0 && bit_idx_o == '0));

endmodule

// File: tb/sec_ecc_fixer_tb_top.sv
module sec_ecc_fixer_tb_top;

   localparam int SEC = 400;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [2:0][7:0] stored_code_i = '0;
   logic [2:0][7:0] calc_code_i = '0;
   logic            busy_o;
   logic            done_o;
   logic [1:0]      status_o;
   logic [8:0]      byte_idx_o;
   logic [2:0]      bit_idx_o;
   logic            buf_en_o;
   logic            buf_we_o;
   logic [8:0]      buf_addr_o;
   logic [7:0]      buf_wdata_o;
   logic [7:0]      buf_rdata_i = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [7:0] mem [SEC];
   logic [7:0] exp_mem [SEC];

   always #5 clk = ~clk;

   sec_ecc_fixer #(.CODE_BYTES(3), .SECTOR_BYTES(SEC)) dut_i (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .stored_code_i (stored_code_i), .calc_code_i (calc_code_i),
      .busy_o (busy_o), .done_o (done_o), .status_o (status_o),
      .byte_idx_o (byte_idx_o), .bit_idx_o (bit_idx_o),
      .buf_en_o (buf_en_o), .buf_we_o (buf_we_o), .buf_addr_o (buf_addr_o),
      .buf_wdata_o (buf_wdata_o), .buf_rdata_i (buf_rdata_i)
   );

   // behavioural buffer: one cycle read latency
   always @(posedge clk) begin
      if (buf_en_o) begin
         if (buf_we_o) mem[buf_addr_o] <= buf_wdata_o;
         else          buf_rdata_i <= mem[buf_addr_o];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int mk_fix(input int b, input int k);
      int hi;
      hi = ((b & 511) << 3) | (k & 7);
      return (hi << 12) | (~hi & 12'hFFF);
   endfunction

   // one check: stored bytes and a difference; optional start while busy
   task automatic run(input int stored, input int diff, input bit inject);
      int lo, hi, st, eb, ek, lat, bad;
      bit fix;
      lo = diff & 12'hFFF;
      hi = (diff >> 12) & 12'hFFF;
      eb = 0; ek = 0; fix = 0;
      if (diff == 0) st = 0;
      else if ((lo ^ hi) == 12'hFFF) begin
         if ((hi >> 3) < SEC) begin
            st = 1; eb = hi >> 3; ek = hi & 7; fix = 1;
         end else st = 3;
      end else if ($countones(diff) == 1) st = 2;
      else st = 3;
      lat = fix ? 3 : 1;
      if (fix) exp_mem[eb] = exp_mem[eb] ^ 8'(1 << ek);

      @(negedge clk);
      for (int g = 0; g < 3; g++) begin
         stored_code_i[g] = 8'(stored >> (8*g));
         calc_code_i[g]   = 8'((stored ^ diff) >> (8*g));
      end
      start_i = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk(done_o == (k == lat), "R8 done timing", done_o, (k == lat));
         chk(buf_en_o == (fix && (k == 1 || k == 2)), fix ? "R4 access" : "R2/R5/R7 no access",
             buf_en_o, (fix && (k == 1 || k == 2)));
         if (fix && k == 1)
            chk(!buf_we_o && buf_addr_o == 9'(eb), "R4 read addr", buf_addr_o, eb);
         if (fix && k == 2) begin
            chk(buf_we_o && buf_addr_o == 9'(eb), "R4 write addr", buf_addr_o, eb);
            chk(buf_wdata_o == (mem[eb] ^ 8'(1 << ek)), "R4 write data",
                buf_wdata_o, mem[eb] ^ 8'(1 << ek));
         end
         if (k == lat) begin
            chk(status_o == 2'(st), "R3/R5/R6/R7 status", status_o, st);
            chk(byte_idx_o == 9'(eb), "R3/R10 byte index", byte_idx_o, eb);
            chk(bit_idx_o == 3'(ek), "R3/R10 bit index", bit_idx_o, ek);
         end
         if (k == 1 && inject) begin
            // R9 second request while busy, an uncorrectable pair
            stored_code_i = '0;
            calc_code_i   = 24'h000003;
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         if (k == 1 && inject) chk(busy_o, "R9 busy", busy_o, 1);
      end
      bad = 0;
      for (int a = 0; a < SEC; a++) if (mem[a] !== exp_mem[a]) bad++;
      chk(bad == 0, "R4/R6 buffer image", bad, 0);
   endtask

   initial begin
      while (1) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      for (int a = 0; a < SEC; a++) begin
         mem[a] = 8'((a * 37 + 11) & 255);
         exp_mem[a] = mem[a];
      end
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!done_o && !busy_o && !buf_en_o && status_o == 0, "R11 in reset",
          {done_o, busy_o, buf_en_o, status_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !busy_o && !buf_en_o && status_o == 0, "R11 after reset",
          {done_o, busy_o, buf_en_o, status_o}, 0);

      run(24'hA53C0F, 0, 0);                  // R2 clean
      run(24'h123456, mk_fix(0, 0), 0);       // R3 R1 first byte
      run(24'h0F1E2D, mk_fix(5, 7), 0);       // R3
      run(24'hFFFFFF, mk_fix(123, 4), 0);     // R3
      run(24'h00A0B0, mk_fix(SEC - 1, 3), 0); // R3 last byte in sector
      run(24'h5A5A5A, mk_fix(SEC, 1), 0);     // R5 just past the end
      run(24'h010203, mk_fix(511, 6), 0);     // R5
      run(24'h778899, 24'h000001, 0);         // R6
      run(24'h778899, 24'h800000, 0);         // R6
      run(24'h334455, 24'h001000, 0);         // R6
      run(24'h334455, 24'h000003, 0);         // R7
      run(24'h9ABCDE, 24'h123456, 0);         // R7
      run(24'hC0FFEE, mk_fix(200, 2), 1);     // R9 start while busy
      run(24'h001100, mk_fix(5, 7), 0);       // R4 flip back
      repeat (3) @(negedge clk);
      chk(!done_o && !buf_en_o, "R9 quiet after run", done_o, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule